// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. It runs from its own receive clock, which ticks 16 times per bit. The line is first passed through a small synchronizer. A falling edge on the line starts a character. The line is checked again half a bit later: if it has gone back high, the start is treated as a glitch and dropped. Otherwise each data bit, the optional parity bit and the stop bit are sampled at the middle of their bit periods.

A character has 5 to 8 data bits and is received least significant bit first. It is moved into an 8-bit holding buffer only when its stop bit is sampled high. The unused upper bits of the buffer read as zero. An active-low ready output shows that the buffer holds an unread character. Four sticky flags report these errors:
- overrun;
- parity mismatch;
- framing error;
- break (the whole frame held low).

The host reads data with a one-cycle buffer-read strobe and clears the flags with a one-cycle status-read strobe. Character length and parity come in on a line-control input bus, which must stay stable while a character is being received.

Top module: `uart_rx_unit`

## Requirements
- R1: After reset `rdy_n` is 1 and `err_overrun`, `err_parity`, `err_frame` and `brk_det` are all 0.
- R2: A character starts on a falling edge of the synchronized line. If the line is high again half a bit period (8 ticks) after that edge, the start is dropped: no character is loaded and the receiver waits for the next falling edge.
- R3: The first data bit is sampled 1.5 bit periods after the start edge, and every later bit one bit period (16 ticks) after the one before it. Data is taken least significant bit first. Line disturbances confined to the first four and last two ticks of a bit do not change the result.
- R4: `char_len` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. The data lands in the low bits of `rx_data`, and the unused upper bits are 0.
- R5: With `par_en`=1, one parity bit follows the data. `par_odd`=0 selects even parity, meaning data ones plus the parity bit make an even count. `par_odd`=1 selects odd parity. On a mismatch, `err_parity` is set when the character completes.
- R6: If the stop bit is sampled low, `err_frame` is set. In that case `rx_data` and `rdy_n` keep their previous values.
- R7: A character with a high stop bit is loaded into `rx_data` and drives `rdy_n` to 0. A `rd_buf` pulse returns `rdy_n` to 1.
- R8: If a character loads while `rdy_n` is 0 and no `rd_buf` pulse arrives in the same cycle, `err_overrun` is set and `rx_data` takes the new character.
- R9: If all data bits, the parity bit (when enabled) and the stop bit are sampled low, `brk_det` is set together with `err_frame`.
- R10: A `rd_stat` pulse clears all four error flags, unless a new character completes in that same cycle.
- R11: After a frame ends, a new character needs the line to go high and then fall again. A line held low does not start repeated characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk | input | 1 | Receive clock, 16 ticks per bit |
| rst | input | 1 | Asynchronous reset, active high |
| rx_in | input | 1 | Serial line, idle high |
| char_len | input | 2 | Data bit count select (5 to 8) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rd_buf | input | 1 | One-cycle strobe: host reads the buffer |
| rd_stat | input | 1 | One-cycle strobe: host reads and clears the flags |
| rx_data | output | 8 | Receive buffer |
| rdy_n | output | 1 | Low while an unread character is held |
| err_overrun | output | 1 | Character lost to an unread buffer |
| err_parity | output | 1 | Parity mismatch |
| err_frame | output | 1 | Stop bit sampled low |
| brk_det | output | 1 | Whole frame held low |

## Verification
The bench builds the block with its defaults: 16 ticks per bit and a two-stage synchronizer. With these values the half-bit false-start check falls on tick 8, and the mid-bit sample lands far enough from both bit edges that corruption of the outer ticks of each bit tests the centring. Random frames cover all four lengths, all parity settings and deliberate parity faults. Directed frames reach the following cases:
- overrun;
- a low stop bit;
- a held-low break that must not restart;
- a short glitch that must not produce a character.

// File: rtl/uart_rx_unit.sv
module uart_rx_unit #(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       rclk,
  input  logic       rst,
  input  logic       rx_in,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rd_buf,
  input  logic       rd_stat,
  output logic [7:0] rx_data,
  output logic       rdy_n,
  output logic       err_overrun,
  output logic       err_parity,
  output logic       err_frame,
  output logic       brk_det
);
  localparam int CW   = $clog2(OVERSAMPLE);
  localparam int HALF = OVERSAMPLE / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t                    state;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_q;
  logic [CW-1:0]          cnt;
  logic [2:0]             bitn;
  logic [7:0]             shreg;
  logic                   pbit;

  wire       rx_s     = sync_q[SYNC_STAGES-1];
  wire       fall     = rx_q & ~rx_s;
  wire       tick_end = (cnt == CW'(OVERSAMPLE - 1));
  wire       mid      = (cnt == CW'(HALF - 1));
  wire [2:0] last_bit = {1'b1, char_len};
  wire [7:0] aligned  = shreg >> (2'd3 - char_len);
  wire       par_bad  = par_en & ((^shreg ^ pbit) != par_odd);
  wire       stop_hit = (state == S_STOP) && tick_end;
  wire       ld       = stop_hit & rx_s;
  wire       stop_bad = stop_hit & ~rx_s;
  wire       all_low  = (shreg == 8'h00) & ~(par_en & pbit);

  always_ff @(posedge rclk or posedge rst) begin
    if (rst) begin
      sync_q <= '1;
      rx_q   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
      rx_q   <= rx_s;
    end
  end

  always_ff @(posedge rclk or posedge rst) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (fall) begin
            state <= S_START;
            shreg <= '0;
            pbit  <= 1'b0;
            bitn  <= '0;
          end
        end
        S_START: begin
          if (mid) begin
            cnt   <= '0;
            state <= rx_s ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          cnt <= tick_end ? '0 : cnt + 1'b1;
          if (tick_end) begin
            shreg <= {rx_s, shreg[7:1]};
            bitn  <= bitn + 1'b1;
            if (bitn == last_bit) state <= par_en ? S_PAR : S_STOP;
          end
        end
        S_PAR: begin
          cnt <= tick_end ? '0 : cnt + 1'b1;
          if (tick_end) begin
            pbit  <= rx_s;
            state <= S_STOP;
          end
        end
        S_STOP: begin
          cnt <= tick_end ? '0 : cnt + 1'b1;
          if (tick_end) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge rclk or posedge rst) begin
    if (rst) begin
      rx_data     <= '0;
      rdy_n       <= 1'b1;
      err_overrun <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      brk_det     <= 1'b0;
    end else begin
      if (rd_buf) rdy_n <= 1'b1;
      if (rd_stat) begin
        err_overrun <= 1'b0;
        err_parity  <= 1'b0;
        err_frame   <= 1'b0;
        brk_det     <= 1'b0;
      end
      if (stop_hit && par_bad) err_parity <= 1'b1;
      if (ld) begin
        rx_data <= aligned;
        rdy_n   <= 1'b0;
        if (!rdy_n && !rd_buf) err_overrun <= 1'b1;
      end
      if (stop_bad) begin
        err_frame <= 1'b1;
        if (all_low) brk_det <= 1'b1;
      end
    end
  end

  a_r2_false_start: assert property (@(posedge rclk) disable iff (rst)
    (state == S_START && mid && rx_s) |=> (state == S_IDLE && rdy_n == $past(rdy_n)));

  a_r6_no_load_bad_stop: assert property (@(posedge rclk) disable iff (rst)
    stop_bad |=> (err_frame && $stable(rx_data) && rdy_n == $past(rdy_n)));

  a_r7_load_ready: assert property (@(posedge rclk) disable iff (rst)
    ld |=> (!rdy_n && rx_data == $past(aligned)));

  a_r7_read_clears: assert property (@(posedge rclk) disable iff (rst)
    (rd_buf && !ld) |=> rdy_n);

  a_r8_overrun: assert property (@(posedge rclk) disable iff (rst)
    (ld && !rdy_n && !rd_buf) |=> err_overrun);

  a_r10_status_clear: assert property (@(posedge rclk) disable iff (rst)
    (rd_stat && !stop_hit) |=> (!err_overrun && !err_parity && !err_frame && !brk_det));

  a_r11_no_restart: assert property (@(posedge rclk) disable iff (rst)
    (state == S_IDLE && !fall) |=> (state == S_IDLE));
endmodule

// File: tb/uart_rx_unit_bench.sv
module uart_rx_unit_bench;
  logic       rclk = 0;
  logic       rst = 1;
  logic       rx_in = 1;
  logic [1:0] char_len = 2'b11;
  logic       par_en = 0, par_odd = 0, rd_buf = 0, rd_stat = 0;
  logic [7:0] rx_data;
  logic       rdy_n, err_overrun, err_parity, err_frame, brk_det;
  int         checks = 0, errors = 0, cycles = 0;

  always #5 rclk = ~rclk;

  uart_rx_unit u_uart_rx_unit (
    .rclk(rclk), .rst(rst), .rx_in(rx_in), .char_len(char_len),
    .par_en(par_en), .par_odd(par_odd), .rd_buf(rd_buf), .rd_stat(rd_stat),
    .rx_data(rx_data), .rdy_n(rdy_n), .err_overrun(err_overrun),
    .err_parity(err_parity), .err_frame(err_frame), .brk_det(brk_det));

  always @(posedge rclk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_len(input logic [7:0] d, input int n);
    return d & 8'((1 << n) - 1);
  endfunction

  function automatic logic par_of(input logic [7:0] d, input bit odd);
    return (^d) ^ odd;
  endfunction

  task automatic hold_bit(input logic b, input bit glitch);
    for (int i = 0; i < 16; i++) begin
      @(negedge rclk);
      rx_in = (glitch && (i < 4 || i > 13)) ? ~b : b;
    end
  endtask

  task automatic send(input logic [7:0] d, input int n, input bit flip_par,
                      input logic stop, input bit glitch);
    char_len = 2'(n - 5);
    hold_bit(1'b0, 1'b0);
    for (int i = 0; i < n; i++) hold_bit(d[i], glitch);
    if (par_en) hold_bit(par_of(mask_len(d, n), par_odd) ^ flip_par, glitch);
    hold_bit(stop, 1'b0);
    hold_bit(1'b1, 1'b0);
    hold_bit(1'b1, 1'b0);
  endtask

  task automatic host_read();
    @(negedge rclk); rd_buf = 1; rd_stat = 1;
    @(negedge rclk); rd_buf = 0; rd_stat = 0;
  endtask

  initial begin
    logic [7:0] d, last;
    int n;
    bit fp;
    void'($urandom(32'd7));
    repeat (3) @(negedge rclk);
    rst = 0;
    @(negedge rclk);
    chk(rdy_n == 1 && {err_overrun, err_parity, err_frame, brk_det} == 0, "R1 reset", {rdy_n, err_overrun, err_parity, err_frame, brk_det}, 5'h10);

    for (int k = 0; k < 40; k++) begin
      d = 8'($urandom); n = 5 + int'($urandom_range(0, 3));
      par_en = 1'($urandom); par_odd = 1'($urandom);
      fp = ($urandom_range(0, 3) == 0);
      send(d, n, fp, 1'b1, (k % 3) == 0);
      chk(rx_data == mask_len(d, n), "R3 R4 data", rx_data, mask_len(d, n));
      chk(rdy_n == 0, "R7 ready low", rdy_n, 0);
      chk(err_parity == (fp & par_en), "R5 parity flag", err_parity, fp & par_en);
      chk(err_frame == 0, "R6 no frame err", err_frame, 0);
      host_read();
      chk(rdy_n == 1, "R7 read releases", rdy_n, 1);
      chk(err_parity == 0, "R10 flags cleared", err_parity, 0);
      last = mask_len(d, n);
    end

    par_en = 0;
    send(8'h3C, 8, 0, 1'b1, 0);
    send(8'hA5, 8, 0, 1'b1, 0);
    chk(err_overrun == 1, "R8 overrun set", err_overrun, 1);
    chk(rx_data == 8'hA5, "R8 newest kept", rx_data, 8'hA5);
    host_read();
    chk(err_overrun == 0, "R10 overrun cleared", err_overrun, 0);
    last = 8'hA5;

    send(8'h5A, 8, 0, 1'b0, 0);
    chk(err_frame == 1, "R6 frame err", err_frame, 1);
    chk(rdy_n == 1 && rx_data == last, "R6 buffer unchanged", rx_data, last);
    chk(brk_det == 0, "R9 no break on data", brk_det, 0);
    host_read();

    par_en = 1; par_odd = 1; char_len = 2'b11;
    @(negedge rclk); rx_in = 0;
    repeat (16 * 14) @(negedge rclk);
    chk(brk_det == 1 && err_frame == 1, "R9 break", {brk_det, err_frame}, 3);
    chk(rdy_n == 1, "R11 no restart while low", rdy_n, 1);
    rx_in = 1;
    repeat (40) @(negedge rclk);
    chk(rdy_n == 1, "R11 still no char", rdy_n, 1);
    host_read();
    chk(brk_det == 0 && err_frame == 0, "R10 break cleared", {brk_det, err_frame}, 0);

    par_en = 0;
    @(negedge rclk); rx_in = 0;
    repeat (5) @(negedge rclk);
    rx_in = 1;
    repeat (64) @(negedge rclk);
    chk(rdy_n == 1 && err_frame == 0, "R2 glitch ignored", {rdy_n, err_frame}, 2);
    send(8'h81, 8, 0, 1'b1, 1);
    chk(rx_data == 8'h81 && rdy_n == 0, "R2 recovers after glitch", rx_data, 8'h81);
    host_read();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule